// File: doc/BRIEF.md
# Converter Zero-Offset Calibration and Correction

This block sits between the decimation filter of a delta-sigma converter and the conversion result register. In normal running, every settled filter word that arrives has a stored 16-bit two's-complement zero offset subtracted from it. The result is clamped to the 16-bit signed range and presented one cycle later with a valid strobe. In bipolar range one offset step moves the result by one code. In unipolar range it moves the result by two codes.

A calibration request puts the block into a calibration phase. During this phase it raises a not-ready flag and drives two control lines: one switches off the input multiplexers and the other shorts the converter inputs to common mode. It discards filter words until the filter has settled and keeps the third word as the new offset. A host can also load the offset directly to shift the zero point, except during calibration.

The block watches the analog configuration inputs: gain, range, buffering and rate. A change to any of them marks the stored calibration as stale until the next calibration completes.

Top module: `adc_offset_corrector`

## Requirements
- R1: After synchronous reset, cor_data is 0 and cor_valid, cal_nrdy, mux_off and short_cm are 0. cal_stale is 1 and ofs_value is 0.
- R2: In bipolar range (cfg_unipolar=0), a filter word accepted outside calibration appears on cor_data, one cycle later with cor_valid high, as raw minus ofs_value.
- R3: In unipolar range (cfg_unipolar=1), the value subtracted is twice ofs_value, so an offset of +2 lowers the result by 4.
- R4: A corrected value above 32767 is output as 32767, and one below -32768 as -32768. It never wraps.
- R5: A calibration request raises cal_nrdy, mux_off and short_cm from the next cycle until calibration ends. No cor_valid is produced for words that arrive during calibration, and a further request during calibration has no effect.
- R6: The first and second filter words after calibration starts are discarded. On the third, the offset is loaded and calibration ends in the same cycle. The loaded value is the word itself in bipolar range, or the word arithmetically shifted right by one in unipolar range.
- R7: A host write (ofs_wr) outside calibration loads ofs_wdata into the offset, visible on ofs_value the next cycle. A host write during calibration is ignored.
- R8: cal_stale is set by any change of cfg_gain, cfg_unipolar, cfg_buffered or cfg_rate, and cleared when a calibration completes.
- R9: A word arriving in the same cycle as a host write is corrected with the old offset. A word arriving in the same cycle as a calibration request is still corrected and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Filter word strobe |
| word_data | input | 16 | Filter word, two's complement |
| cal_req | input | 1 | Calibration request pulse |
| ofs_wr | input | 1 | Host offset write strobe |
| ofs_wdata | input | 16 | Host offset value, two's complement |
| cfg_gain | input | 2 | Gain setting |
| cfg_unipolar | input | 1 | 1 = unipolar range, 0 = bipolar |
| cfg_buffered | input | 1 | Input buffer enable |
| cfg_rate | input | 1 | Conversion speed select |
| cor_data | output | 16 | Corrected result |
| cor_valid | output | 1 | Corrected result strobe |
| cal_nrdy | output | 1 | High while calibrating |
| mux_off | output | 1 | Disable input multiplexers |
| short_cm | output | 1 | Short inputs to common mode |
| cal_stale | output | 1 | Calibration invalidated by a configuration change |
| ofs_value | output | 16 | Current stored offset |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is correction and an offset update: the bench drives a filter word together with a host write, and the scoreboard expects the old offset in that result and the new offset in the next one. The second pair is correction and the start of calibration: a word is driven in the same cycle as the request. The bench expects a corrected output for that word, then the not-ready and switch controls from the following cycle, then no output until the third word has been captured.

// File: rtl/adc_ofs_pkg.sv
package adc_ofs_pkg;

  typedef struct packed {
    logic [1:0] gain;
    logic       unipolar;
    logic       buffered;
    logic       rate;
  } adc_cfg_t;

  typedef enum logic {
    ST_RUN = 1'b0,
    ST_CAL = 1'b1
  } cal_state_t;

endpackage

// File: rtl/ofs_cal_fsm.sv
module ofs_cal_fsm #(
  parameter int SETTLE_WORDS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_req,
  input  logic word_valid,
  output logic in_cal,
  output logic cap_en
);
  import adc_ofs_pkg::*;

  localparam int CW = $clog2(SETTLE_WORDS + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_WORDS - 1);

  cal_state_t    state;
  logic [CW-1:0] seen;

  assign in_cal = (state == ST_CAL);
  assign cap_en = in_cal && word_valid && (seen == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      seen  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (cal_req) begin
            state <= ST_CAL;
            seen  <= '0;
          end
        end
        ST_CAL: begin
          if (word_valid) begin
            if (seen == LAST) begin
              state <= ST_RUN;
              seen  <= '0;
            end else begin
              seen <= seen + 1'b1;
            end
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_en,
  input  logic [DW-1:0]         cap_word,
  input  logic                  in_cal,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  input  adc_ofs_pkg::adc_cfg_t cfg,
  output logic [DW-1:0]         ofs,
  output logic                  stale
);
  import adc_ofs_pkg::*;

  adc_cfg_t      cfg_prev;
  logic          cfg_chg;
  logic [DW-1:0] cap_val;

  assign cfg_chg = (cfg != cfg_prev);
  // unipolar: one stored step equals two output codes, so halve the zero word
  assign cap_val = cfg.unipolar ? {cap_word[DW-1], cap_word[DW-1:1]} : cap_word;

  always_ff @(posedge clk) begin
    cfg_prev <= cfg;
    if (rst) begin
      ofs   <= '0;
      stale <= 1'b1;
    end else begin
      if (cap_en)
        ofs <= cap_val;
      else if (wr_en && !in_cal)
        ofs <= wr_data;
      if (cfg_chg)
        stale <= 1'b1;
      else if (cap_en)
        stale <= 1'b0;
    end
  end

endmodule

// File: rtl/ofs_subtract.sv
module ofs_subtract #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] ofs,
  input  logic          unipolar,
  output logic [DW-1:0] dout,
  output logic          dout_valid
);
  localparam int EW = DW + 3;
  localparam logic signed [EW-1:0] MAX_V = {{(EW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [EW-1:0] MIN_V = {{(EW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [EW-1:0] raw_e, ofs_e, sub_e, diff;
  logic [DW-1:0]        clamped;

  always_comb begin
    raw_e = {{(EW-DW){raw[DW-1]}}, raw};
    ofs_e = {{(EW-DW){ofs[DW-1]}}, ofs};
    sub_e = unipolar ? (ofs_e <<< 1) : ofs_e;
    diff  = raw_e - sub_e;
    if (diff > MAX_V)
      clamped = MAX_V[DW-1:0];
    else if (diff < MIN_V)
      clamped = MIN_V[DW-1:0];
    else
      clamped = diff[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= en;
      if (en) dout <= clamped;
    end
  end

endmodule

// File: rtl/adc_offset_corrector.sv
module adc_offset_corrector #(
  parameter int DW           = 16,
  parameter int SETTLE_WORDS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_valid,
  input  logic [DW-1:0] word_data,
  input  logic          cal_req,
  input  logic          ofs_wr,
  input  logic [DW-1:0] ofs_wdata,
  input  logic [1:0]    cfg_gain,
  input  logic          cfg_unipolar,
  input  logic          cfg_buffered,
  input  logic          cfg_rate,
  output logic [DW-1:0] cor_data,
  output logic          cor_valid,
  output logic          cal_nrdy,
  output logic          mux_off,
  output logic          short_cm,
  output logic          cal_stale,
  output logic [DW-1:0] ofs_value
);
  import adc_ofs_pkg::*;

  adc_cfg_t cfg;
  logic     in_cal, cap_en;

  assign cfg = '{gain: cfg_gain, unipolar: cfg_unipolar,
                 buffered: cfg_buffered, rate: cfg_rate};

  ofs_cal_fsm #(.SETTLE_WORDS(SETTLE_WORDS)) u_fsm (
    .clk(clk), .rst(rst), .cal_req(cal_req), .word_valid(word_valid),
    .in_cal(in_cal), .cap_en(cap_en)
  );

  ofs_store #(.DW(DW)) u_store (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_word(word_data),
    .in_cal(in_cal), .wr_en(ofs_wr), .wr_data(ofs_wdata), .cfg(cfg),
    .ofs(ofs_value), .stale(cal_stale)
  );

  ofs_subtract #(.DW(DW)) u_sub (
    .clk(clk), .rst(rst), .en(word_valid && !in_cal), .raw(word_data),
    .ofs(ofs_value), .unipolar(cfg_unipolar),
    .dout(cor_data), .dout_valid(cor_valid)
  );

  assign cal_nrdy = in_cal;
  assign mux_off  = in_cal;
  assign short_cm = in_cal;

endmodule

// File: rtl/adc_ofs_checker.sv
module adc_ofs_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          word_valid,
  input logic          cal_req,
  input logic [1:0]    cfg_gain,
  input logic          cfg_unipolar,
  input logic          cfg_buffered,
  input logic          cfg_rate,
  input logic          cor_valid,
  input logic          cal_nrdy,
  input logic          cal_stale,
  input logic [DW-1:0] ofs_value
);
  logic [4:0] cfg_v;
  assign cfg_v = {cfg_gain, cfg_unipolar, cfg_buffered, cfg_rate};

  p_cal_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!cal_nrdy && cal_req) |=> cal_nrdy);

  p_quiet_in_cal_r5: assert property (@(posedge clk) disable iff (rst)
    (cal_nrdy && $past(cal_nrdy)) |-> !cor_valid);

  p_out_follows_word_r2: assert property (@(posedge clk) disable iff (rst)
    cor_valid |-> $past(word_valid));

  p_ofs_hold_in_cal_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_nrdy && !word_valid) |=> $stable(ofs_value));

  p_stale_on_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_v != $past(cfg_v)) |=> cal_stale);

  p_cal_needs_word_r6: assert property (@(posedge clk) disable iff (rst)
    (cal_nrdy && !word_valid) |=> cal_nrdy);

endmodule

bind adc_offset_corrector adc_ofs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .word_valid(word_valid), .cal_req(cal_req),
  .cfg_gain(cfg_gain), .cfg_unipolar(cfg_unipolar), .cfg_buffered(cfg_buffered),
  .cfg_rate(cfg_rate), .cor_valid(cor_valid), .cal_nrdy(cal_nrdy),
  .cal_stale(cal_stale), .ofs_value(ofs_value)
);

// File: tb/tb_adc_offset_corrector.sv
`timescale 1ns/1ps
module tb_adc_offset_corrector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0, cal_req = 1'b0, ofs_wr = 1'b0;
  logic [15:0] word_data = '0, ofs_wdata = '0;
  logic [1:0]  cfg_gain = 2'd0;
  logic        cfg_unipolar = 1'b0, cfg_buffered = 1'b0, cfg_rate = 1'b0;
  logic [15:0] cor_data, ofs_value;
  logic        cor_valid, cal_nrdy, mux_off, short_cm, cal_stale;

  always #2.5 clk = ~clk;

  adc_offset_corrector dut (.*);

  int    errors = 0, checks = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "R2";

  // bench model
  int m_ofs = 0, m_cnt = 0;
  bit m_cal = 0;

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int s16(logic [15:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit wv, int raw, bit cr, bit ow, int od);
    @(negedge clk);
    word_valid = wv; word_data = 16'(raw);
    cal_req = cr; ofs_wr = ow; ofs_wdata = 16'(od);
    if (wv && !m_cal) begin
      exp_q.push_back(sat16(raw - (cfg_unipolar ? 2 : 1) * m_ofs));
      tag_q.push_back(cur_tag);
    end
    if (m_cal) begin
      if (wv) begin
        m_cnt++;
        if (m_cnt == 3) begin
          m_ofs = cfg_unipolar ? (raw >>> 1) : raw;
          m_cal = 0;
        end
      end
    end else begin
      if (ow) m_ofs = s16(16'(od));
      if (cr) begin m_cal = 1; m_cnt = 0; end
    end
    @(posedge clk);
    #1;
    word_valid = 0; cal_req = 0; ofs_wr = 0;
  endtask

  task automatic word(int raw); drive(1, raw, 0, 0, 0); endtask
  task automatic wr_ofs(int v); drive(0, 0, 0, 1, v); endtask

  task automatic set_cfg(bit u, logic [1:0] g);
    @(negedge clk);
    cfg_unipolar = u; cfg_gain = g;
    @(posedge clk);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && cor_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected output actual=%0d expected=none", s16(cor_data));
      end else begin
        check(tag_q.pop_front(), s16(cor_data), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 cor_data", s16(cor_data), 0);
    check("R1 cor_valid", int'(cor_valid), 0);
    check("R1 cal_nrdy", int'(cal_nrdy), 0);
    check("R1 mux_off", int'(mux_off), 0);
    check("R1 short_cm", int'(short_cm), 0);
    check("R1 cal_stale", int'(cal_stale), 1);
    check("R1 ofs_value", s16(ofs_value), 0);
    rst = 0;

    // R2 bipolar correction
    cur_tag = "R2";
    word(1234); word(-77);
    wr_ofs(100);
    @(negedge clk); check("R7 host write", s16(ofs_value), 100);
    word(50); word(-32000);
    wr_ofs(-250);
    word(0); word(3000);

    // R4 saturation
    cur_tag = "R4";
    wr_ofs(-1000); word(32000);
    wr_ofs(1000);  word(-32000);
    wr_ofs(0);     word(32767);

    // R8 config change, R3 unipolar
    set_cfg(1, 2'd0);
    @(negedge clk); check("R8 stale on cfg", int'(cal_stale), 1);
    cur_tag = "R3";
    wr_ofs(2); word(10); word(-10);

    // R9 word with cal_req, R5 controls
    cur_tag = "R9 word with cal_req";
    drive(1, 400, 1, 0, 0);
    @(negedge clk);
    check("R5 cal_nrdy", int'(cal_nrdy), 1);
    check("R5 mux_off", int'(mux_off), 1);
    check("R5 short_cm", int'(short_cm), 1);
    wr_ofs(777);
    @(negedge clk); check("R7 write ignored in cal", s16(ofs_value), 2);
    drive(0, 0, 1, 0, 0);
    word(40); word(50);
    @(negedge clk);
    check("R5 no output in cal", int'(cor_valid), 0);
    check("R6 still calibrating", int'(cal_nrdy), 1);
    check("R6 no capture yet", s16(ofs_value), 2);
    word(61);
    @(negedge clk);
    check("R6 cal done", int'(cal_nrdy), 0);
    check("R6 unipolar capture", s16(ofs_value), 30);
    check("R8 stale cleared", int'(cal_stale), 0);
    cur_tag = "R3 after cal";
    word(61);

    // bipolar calibration
    set_cfg(0, 2'd1);
    drive(0, 0, 1, 0, 0);
    word(-5); word(-7); word(-9);
    @(negedge clk);
    check("R6 bipolar capture", s16(ofs_value), -9);
    cur_tag = "R6 correction";
    word(100);

    // R9 word with host write
    cur_tag = "R9 word with write";
    drive(1, 1000, 0, 1, 500);
    cur_tag = "R9 new offset";
    word(1000);

    repeat (3) @(negedge clk);
    check("R5 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule